// File: doc/BRIEF.md
# Multiprocessor-Filtered UART Receiver

This block is an asynchronous serial receiver with a wake-up filter for multi-drop links. Several receivers share one line, and each frame can carry an extra multiprocessor bit between the last data bit and the stop bit. When that bit is 1, the frame is an address. A receiver that is not being addressed sets its wake enable and then ignores all traffic until the next address frame. That frame clears the wake enable in hardware and is received normally, so software reads the address and decides whether to stay awake.

The line is sampled on a 16x oversampling enable that comes from an external baud generator. A start bit has to be confirmed at its middle. Each later bit is sampled once per bit period at its centre. A completed frame goes into a data register and sets status flags. Software clears the flags by writing zeros. Two interrupt outputs are derived from the flags: one for received data and one for errors.

Top module: `mpf_uart_rx`

## Requirements
- R1: With the receive enable (control bit 0) at 0, no start bit is accepted and the line is ignored. With it at 1, a low line seen on an oversample tick begins a frame.
- R2: A start bit is confirmed only if the line is still low 8 ticks after detection. If it is not, the receiver returns to idle and nothing is recorded.
- R3: After the start bit, 8 data bits (LSB first) are sampled every 16 ticks, then the multiprocessor bit only when multiprocessor mode (control bit 1) is 1, then the stop bit.
- R4: A completed frame taken while the data-full flag is 0 loads the data register and sets data-full. It also loads the multiprocessor flag with the received bit, or with 0 outside multiprocessor mode. A low stop bit additionally sets the framing-error flag.
- R5: A completed frame taken while data-full is 1 sets the overrun flag. It leaves the data register, the multiprocessor flag and the framing-error flag unchanged.
- R6: A status write clears each flag whose write bit is 0 and keeps each flag whose write bit is 1. The bit positions are: 0 data-full, 1 framing error, 2 overrun. A hardware set in the same cycle wins over the clear.
- R7: Clearing receive enable abandons any frame in progress. All flags and the data register keep their values.
- R8: After reset, all control bits, all flags, the data register and both interrupts are 0.
- R9: Filtering is active only when the wake enable (control bit 2) and multiprocessor mode are both 1. With multiprocessor mode at 0, the wake enable has no effect and is never cleared by hardware.
- R10: While filtering, a frame whose multiprocessor bit is 0 changes no flag and no data, even with a low stop bit or with data-full set. The wake enable stays 1.
- R11: While filtering, a frame whose multiprocessor bit is 1 clears the wake enable and is then handled as in R4 and R5.
- R12: The receive interrupt is data-full AND receive-interrupt enable (control bit 3) AND NOT filtering. The error interrupt is (framing error OR overrun) AND receive-interrupt enable AND NOT filtering.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| os_tick_i | input | 1 | Oversample enable, 16 per bit period |
| rxd_i | input | 1 | Serial line, idle high |
| ctl_we_i | input | 1 | Control register write strobe |
| ctl_wdata_i | input | 4 | Control write data: rx enable, mp mode, wake enable, irq enable |
| ctl_o | output | 4 | Control register contents |
| sts_we_i | input | 1 | Status write strobe |
| sts_wdata_i | input | 3 | Status write data, 0 clears: full, framing, overrun |
| rx_data_o | output | 8 | Receive data register |
| full_o | output | 1 | Data-full flag |
| ferr_o | output | 1 | Framing-error flag |
| ovr_o | output | 1 | Overrun flag |
| mpb_o | output | 1 | Multiprocessor bit of the last accepted frame |
| rx_irq_o | output | 1 | Receive interrupt |
| err_irq_o | output | 1 | Error interrupt |

## Verification
A wrong bit counter or sample point appears as a wrong data byte or a spurious framing error in the frame where it occurs. A wrongly latched frame length appears as a wrong multiprocessor flag. A filter that leaks shows up as data-full or framing-error rising after a data frame that should have been dropped. A filter that fails to wake shows up as the wake enable still reading 1 after an address frame. Either fault is visible at the ports one clock after the stop-bit sample. A stale overrun decision changes the data register when it should be held, and that is seen as soon as the next frame completes.

// File: rtl/mpf_uart_pkg.sv
package mpf_uart_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_START, ST_BITS} rx_state_e;

  localparam int CTL_W      = 4;
  localparam int CTL_RXEN   = 0;
  localparam int CTL_MPMODE = 1;
  localparam int CTL_WAKE   = 2;
  localparam int CTL_IRQEN  = 3;

  localparam int STS_W      = 3;
  localparam int STS_FULL   = 0;
  localparam int STS_FERR   = 1;
  localparam int STS_OVR    = 2;
endpackage

// File: rtl/mpf_rx_sync.sv
module mpf_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q[i] <= 1'b1;
      else if (i == 0) q[i] <= d_i;
      else q[i] <= q[(i > 0) ? i - 1 : 0];
    end
  end

  assign q_o = q[STAGES-1];
endmodule

// File: rtl/mpf_rx_frame.sv
module mpf_rx_frame
  import mpf_uart_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int OS_RATE = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_en_i,
  input  logic              mp_mode_i,
  input  logic              tick_i,
  input  logic              rxd_i,
  output logic              done_o,
  output logic [DATA_W-1:0] data_o,
  output logic              mpb_o,
  output logic              stop_o,
  output logic              busy_o
);
  localparam int CW = $clog2(OS_RATE);
  localparam int IW = $clog2(DATA_W + 2);
  localparam logic [CW-1:0] CNT_HALF = CW'(OS_RATE / 2 - 1);
  localparam logic [CW-1:0] CNT_FULL = CW'(OS_RATE - 1);
  localparam logic [IW-1:0] LAST_MP  = IW'(DATA_W + 1);
  localparam logic [IW-1:0] LAST_PL  = IW'(DATA_W);

  rx_state_e         state;
  logic [CW-1:0]     cnt;
  logic [IW-1:0]     idx;
  logic [DATA_W-1:0] sh;
  logic              mp_lat, mpb_r, stop_r, done_r;
  logic [IW-1:0]     last;

  assign last = mp_lat ? LAST_MP : LAST_PL;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      idx    <= '0;
      sh     <= '0;
      mp_lat <= 1'b0;
      mpb_r  <= 1'b0;
      stop_r <= 1'b1;
      done_r <= 1'b0;
    end else begin
      done_r <= 1'b0;
      if (!rx_en_i) begin
        state <= ST_IDLE;
      end else if (tick_i) begin
        unique case (state)
          ST_IDLE: if (!rxd_i) begin
            state  <= ST_START;
            cnt    <= '0;
            mp_lat <= mp_mode_i;
          end
          ST_START: begin
            if (cnt == CNT_HALF) begin
              cnt   <= '0;
              idx   <= '0;
              mpb_r <= 1'b0;
              state <= rxd_i ? ST_IDLE : ST_BITS;  // glitch rejected
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_BITS: begin
            if (cnt == CNT_FULL) begin
              cnt <= '0;
              if (idx == last) begin
                stop_r <= rxd_i;
                done_r <= 1'b1;
                state  <= ST_IDLE;
              end else begin
                if (idx < LAST_PL) sh <= {rxd_i, sh[DATA_W-1:1]};
                else mpb_r <= rxd_i;
                idx <= idx + 1'b1;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  assign done_o = done_r;
  assign data_o = sh;
  assign mpb_o  = mp_lat & mpb_r;
  assign stop_o = stop_r;
  assign busy_o = (state != ST_IDLE);
endmodule

// File: rtl/mpf_rx_regs.sv
module mpf_rx_regs
  import mpf_uart_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctl_we_i,
  input  logic [CTL_W-1:0]  ctl_wdata_i,
  input  logic              sts_we_i,
  input  logic [STS_W-1:0]  sts_wdata_i,
  input  logic              done_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              mpb_i,
  input  logic              stop_i,
  output logic [CTL_W-1:0]  ctl_o,
  output logic              filt_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              full_o,
  output logic              ferr_o,
  output logic              ovr_o,
  output logic              mpb_o,
  output logic              rx_irq_o,
  output logic              err_irq_o
);
  logic [CTL_W-1:0] ctl;
  logic filt, accept;

  assign filt   = ctl[CTL_WAKE] & ctl[CTL_MPMODE];
  assign accept = done_i & (~filt | mpb_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl <= '0;
    end else begin
      if (ctl_we_i) ctl <= ctl_wdata_i;
      if (accept && filt) ctl[CTL_WAKE] <= 1'b0;  // self-clearing wake
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_data_o <= '0;
      full_o    <= 1'b0;
      ferr_o    <= 1'b0;
      ovr_o     <= 1'b0;
      mpb_o     <= 1'b0;
    end else begin
      if (sts_we_i) begin
        if (!sts_wdata_i[STS_FULL]) full_o <= 1'b0;
        if (!sts_wdata_i[STS_FERR]) ferr_o <= 1'b0;
        if (!sts_wdata_i[STS_OVR])  ovr_o  <= 1'b0;
      end
      if (accept) begin
        if (full_o) begin
          ovr_o <= 1'b1;
        end else begin
          rx_data_o <= data_i;
          full_o    <= 1'b1;
          mpb_o     <= mpb_i;
          if (!stop_i) ferr_o <= 1'b1;
        end
      end
    end
  end

  assign ctl_o     = ctl;
  assign filt_o    = filt;
  assign rx_irq_o  = ctl[CTL_IRQEN] & ~filt & full_o;
  assign err_irq_o = ctl[CTL_IRQEN] & ~filt & (ferr_o | ovr_o);
endmodule

// File: rtl/mpf_uart_rx.sv
module mpf_uart_rx
  import mpf_uart_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int OS_RATE     = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              os_tick_i,
  input  logic              rxd_i,
  input  logic              ctl_we_i,
  input  logic [3:0]        ctl_wdata_i,
  output logic [3:0]        ctl_o,
  input  logic              sts_we_i,
  input  logic [2:0]        sts_wdata_i,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              full_o,
  output logic              ferr_o,
  output logic              ovr_o,
  output logic              mpb_o,
  output logic              rx_irq_o,
  output logic              err_irq_o
);
  logic              rxd_s;
  logic              frm_done, frm_mpb, frm_stop, frm_busy, filt;
  logic [DATA_W-1:0] frm_data;

  mpf_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (rxd_i),
    .q_o   (rxd_s)
  );

  mpf_rx_frame #(.DATA_W(DATA_W), .OS_RATE(OS_RATE)) u_frame (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rx_en_i  (ctl_o[CTL_RXEN]),
    .mp_mode_i(ctl_o[CTL_MPMODE]),
    .tick_i   (os_tick_i),
    .rxd_i    (rxd_s),
    .done_o   (frm_done),
    .data_o   (frm_data),
    .mpb_o    (frm_mpb),
    .stop_o   (frm_stop),
    .busy_o   (frm_busy)
  );

  mpf_rx_regs #(.DATA_W(DATA_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ctl_we_i   (ctl_we_i),
    .ctl_wdata_i(ctl_wdata_i),
    .sts_we_i   (sts_we_i),
    .sts_wdata_i(sts_wdata_i),
    .done_i     (frm_done),
    .data_i     (frm_data),
    .mpb_i      (frm_mpb),
    .stop_i     (frm_stop),
    .ctl_o      (ctl_o),
    .filt_o     (filt),
    .rx_data_o  (rx_data_o),
    .full_o     (full_o),
    .ferr_o     (ferr_o),
    .ovr_o      (ovr_o),
    .mpb_o      (mpb_o),
    .rx_irq_o   (rx_irq_o),
    .err_irq_o  (err_irq_o)
  );
endmodule

// File: rtl/mpf_uart_rx_chk.sv
module mpf_uart_rx_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [3:0]        ctl_o,
  input logic              sts_we_i,
  input logic [DATA_W-1:0] rx_data_o,
  input logic              full_o,
  input logic              ferr_o,
  input logic              ovr_o,
  input logic              rx_irq_o,
  input logic              err_irq_o,
  input logic              done_i,
  input logic              mpb_i,
  input logic              busy_i
);
  logic filt;
  assign filt = ctl_o[2] & ctl_o[1];

  // R1, R7: receiver idles one cycle after enable is low
  a_r7_abort_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctl_o[0] |=> !busy_i);

  // R4: accepted frame into an empty register sets data-full
  a_r4_full_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && !full_o && (!filt || mpb_i)) |=> full_o);

  // R5: frame into a full register sets overrun and keeps data
  a_r5_overrun: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && full_o && (!filt || mpb_i)) |=> ovr_o && $stable(rx_data_o));

  // R10: filtered data frame changes nothing
  a_r10_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && filt && !mpb_i && !sts_we_i) |=>
      $stable(rx_data_o) && $stable(full_o) && $stable(ferr_o) && $stable(ovr_o) && ctl_o[2]);

  // R11: address frame clears wake enable
  a_r11_wake_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && filt && mpb_i) |=> !ctl_o[2]);

  // R12: interrupts silent while filtering
  a_r12_irq_block: assert property (@(posedge clk_i) disable iff (!rst_ni)
    filt |-> !rx_irq_o && !err_irq_o);
endmodule

bind mpf_uart_rx mpf_uart_rx_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .ctl_o    (ctl_o),
  .sts_we_i (sts_we_i),
  .rx_data_o(rx_data_o),
  .full_o   (full_o),
  .ferr_o   (ferr_o),
  .ovr_o    (ovr_o),
  .rx_irq_o (rx_irq_o),
  .err_irq_o(err_irq_o),
  .done_i   (frm_done),
  .mpb_i    (frm_mpb),
  .busy_i   (frm_busy)
);

// File: tb/sim_mpf_uart_rx.sv
module sim_mpf_uart_rx;
  localparam int CLK_PERIOD = 10;
  localparam int BIT_CLK    = 32;  // 16 ticks, tick every 2nd clock

  typedef struct packed {
    logic [7:0] data;
    logic       mpb;
    logic       ferr;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       os_tick = 1'b0;
  logic       rxd = 1'b1;
  logic       ctl_we = 1'b0;
  logic [3:0] ctl_wdata = '0;
  logic [3:0] ctl;
  logic       sts_we = 1'b0;
  logic [2:0] sts_wdata = '1;
  logic [7:0] rx_data;
  logic       full, ferr, ovr, mpb, rx_irq, err_irq;

  int   checks = 0;
  int   errors = 0;
  bit   finished = 1'b0;
  exp_t exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(negedge clk) os_tick <= ~os_tick;

  mpf_uart_rx u0 (
    .clk_i(clk), .rst_ni(rst_n), .os_tick_i(os_tick), .rxd_i(rxd),
    .ctl_we_i(ctl_we), .ctl_wdata_i(ctl_wdata), .ctl_o(ctl),
    .sts_we_i(sts_we), .sts_wdata_i(sts_wdata),
    .rx_data_o(rx_data), .full_o(full), .ferr_o(ferr), .ovr_o(ovr),
    .mpb_o(mpb), .rx_irq_o(rx_irq), .err_irq_o(err_irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_ctl(input logic [3:0] v);
    @(negedge clk); ctl_we = 1'b1; ctl_wdata = v;
    @(negedge clk); ctl_we = 1'b0;
  endtask

  task automatic wr_sts(input logic [2:0] v);
    @(negedge clk); sts_we = 1'b1; sts_wdata = v;
    @(negedge clk); sts_we = 1'b0; sts_wdata = '1;
  endtask

  task automatic send(input logic [7:0] d, input bit has_mp, input bit mp, input bit stop_ok);
    @(negedge clk); rxd = 1'b0;
    repeat (BIT_CLK) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxd = d[i];
      repeat (BIT_CLK) @(negedge clk);
    end
    if (has_mp) begin
      rxd = mp;
      repeat (BIT_CLK) @(negedge clk);
    end
    rxd = stop_ok;
    repeat (BIT_CLK) @(negedge clk);
    rxd = 1'b1;
    repeat (BIT_CLK) @(negedge clk);
  endtask

  task automatic expect_rx(input logic [7:0] d, input bit m, input bit fe);
    exp_t e;
    e.data = d; e.mpb = m; e.ferr = fe;
    exp_q.push_back(e);
  endtask

  // monitor: each rise of data-full is compared to the next expected item
  logic full_q = 1'b0;
  always @(negedge clk) begin
    if (rst_n && full && !full_q) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R4 unexpected frame", int'(rx_data), 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(rx_data == e.data, "R3 data", int'(rx_data), int'(e.data));
        chk(mpb == e.mpb, "R4 mpb flag", int'(mpb), int'(e.mpb));
        chk(ferr == e.ferr, "R4 framing", int'(ferr), int'(e.ferr));
      end
    end
    full_q <= full;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R8 reset state
    chk(ctl == 4'h0, "R8 ctl", int'(ctl), 0);
    chk({full, ferr, ovr, mpb} == 4'h0, "R8 flags", int'({full, ferr, ovr, mpb}), 0);
    chk({rx_irq, err_irq} == 2'b00 && rx_data == 8'h00, "R8 irq/data", int'({rx_irq, err_irq, rx_data}), 0);

    // R1 receiver off
    send(8'h3C, 0, 0, 1);
    chk(!full, "R1 disabled", int'(full), 0);

    // R3/R4 plain frame
    set_ctl(4'b1001);
    expect_rx(8'hA5, 0, 0);
    send(8'hA5, 0, 0, 1);
    chk(rx_irq, "R12 rx irq", int'(rx_irq), 1);
    chk(!err_irq, "R12 no err irq", int'(err_irq), 0);

    // R5 overrun
    send(8'h5A, 0, 0, 1);
    chk(ovr, "R5 overrun", int'(ovr), 1);
    chk(rx_data == 8'hA5, "R5 data kept", int'(rx_data), 'hA5);
    chk(err_irq, "R12 err irq", int'(err_irq), 1);

    // R6 selective clears
    wr_sts(3'b011);
    chk(!ovr && full, "R6 clear ovr only", int'({ovr, full}), 1);
    wr_sts(3'b110);
    chk(!full && !rx_irq, "R6 clear full", int'({full, rx_irq}), 0);

    // R4 framing error
    expect_rx(8'hC3, 0, 1);
    send(8'hC3, 0, 0, 0);
    chk(ferr && err_irq, "R4 ferr set", int'({ferr, err_irq}), 3);
    wr_sts(3'b110);

    // R7 flags hold with receiver off, abort mid-frame
    set_ctl(4'b0000);
    chk(ferr && !full, "R7 flags hold", int'({ferr, full}), 2);
    set_ctl(4'b1001);
    @(negedge clk); rxd = 1'b0;
    repeat (3*BIT_CLK) @(negedge clk);
    set_ctl(4'b0000);
    rxd = 1'b1;
    repeat (10*BIT_CLK) @(negedge clk);
    set_ctl(4'b1001);
    chk(!full && ferr, "R7 aborted frame dropped", int'({full, ferr}), 1);
    wr_sts(3'b000);
    expect_rx(8'h81, 0, 0);
    send(8'h81, 0, 0, 1);
    wr_sts(3'b000);

    // R2 start glitch
    @(negedge clk); rxd = 1'b0;
    repeat (6) @(negedge clk);
    rxd = 1'b1;
    repeat (2*BIT_CLK) @(negedge clk);
    chk(!full && !ferr, "R2 glitch rejected", int'({full, ferr}), 0);
    expect_rx(8'h7E, 0, 0);
    send(8'h7E, 0, 0, 1);
    wr_sts(3'b000);

    // R3/R9 multiprocessor frames, no filtering
    set_ctl(4'b1011);
    expect_rx(8'h12, 0, 0);
    send(8'h12, 1, 0, 1);
    wr_sts(3'b000);
    expect_rx(8'h34, 1, 0);
    send(8'h34, 1, 1, 1);
    chk(mpb, "R4 mpb set", int'(mpb), 1);
    wr_sts(3'b000);

    // R10 filtered data frame with bad stop
    set_ctl(4'b1111);
    send(8'h55, 1, 0, 0);
    chk(!full && !ferr && !ovr, "R10 dropped flags", int'({full, ferr, ovr}), 0);
    chk(ctl[2], "R10 wake kept", int'(ctl[2]), 1);

    // R11 address frame wakes
    expect_rx(8'h09, 1, 0);
    send(8'h09, 1, 1, 1);
    chk(!ctl[2], "R11 wake cleared", int'(ctl[2]), 0);
    chk(rx_irq, "R11 irq reenabled", int'(rx_irq), 1);

    // R12/R10 blocked irq and no overrun while filtering
    set_ctl(4'b1111);
    chk(!rx_irq, "R12 irq blocked", int'(rx_irq), 0);
    send(8'h66, 1, 0, 1);
    chk(!ovr && rx_data == 8'h09, "R10 no overrun", int'({ovr, rx_data}), 'h09);
    set_ctl(4'b1011);
    chk(rx_irq, "R12 irq restored", int'(rx_irq), 1);
    wr_sts(3'b000);

    // R9 wake ignored without mp mode
    set_ctl(4'b1101);
    expect_rx(8'hF0, 0, 0);
    send(8'hF0, 0, 0, 1);
    chk(ctl[2] && rx_irq, "R9 wake ignored", int'({ctl[2], rx_irq}), 3);

    chk(exp_q.size() == 0, "R4 all frames seen", exp_q.size(), 0);
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule